// File: doc/BRIEF.md
# Serial CRC-32 Generator and Residue Checker

This block computes a 32-bit cyclic redundancy check over a serial bit stream, one bit per clock, for a link that sends the least significant bit of each byte first. The same register serves two uses. On the transmit side, the frame's message bits are streamed in and the inverted register value is read out as the check word, which is then sent least significant bit first. On the receive side, the whole frame, including its trailing check word, is streamed in. An end-of-frame strobe then asks whether the register holds the fixed residue that every error-free frame leaves behind.

The register is loaded with all ones at the start of each frame, so leading zero bits change the result. The check word is the inverted remainder, so trailing zero bits are caught as well. Each incoming bit is merged into the register at the point where the divide step needs it. Because of this, no trailing zeros have to be shifted in to make room for the check word. The polynomial is 0x04C11DB7, used here in its reflected form 0xEDB88320.

Serial input uses a valid/ready handshake. The block never applies back-pressure: `in_ready` is high whenever reset is low. A bit is consumed on every clock edge where `in_valid` and `in_ready` are both high. When `in_valid` is low, the data line is ignored.

Top module: `crc32_serial_unit`

## Requirements
- R1: Each accepted bit `b` updates the register `r` as follows. Form `t = r ^ b`, where `b` enters at bit 0. The new value is `(t >> 1) ^ 0xEDB88320` when `t[0]` is 1, and `t >> 1` otherwise.
- R2: A `frame_start` pulse loads the register with 0xFFFFFFFF. A data bit offered in the same cycle is discarded. A zero byte placed before a message changes the check word.
- R3: `crc_out` is the bitwise inverse of the register. It reflects the last accepted bit in the cycle after that bit is clocked. For the ASCII bytes "123456789", sent LSB first, it reads 0xCBF43926.
- R4: Suppose a message is followed by its `crc_out` value, sent LSB first. The register then holds 0xDEBB20E3. This is true for every message, including one that is empty or a single byte.
- R5: Cycles with `in_valid` low leave the register unchanged, whatever value `in_data` carries.
- R6: `check_valid` is high for exactly one cycle, the cycle after a `frame_end` strobe, and low at all other times.
- R7: `check_pass` is high only while `check_valid` is high. It is high exactly when the register held 0xDEBB20E3 at the `frame_end` edge. Any single flipped bit, or a zero byte appended after the check word, makes it low.
- R8: A synchronous reset loads the register with all ones, giving `crc_out` = 0, and clears `check_valid` and `check_pass`. `in_ready` is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Loads the register with all ones |
| in_valid | input | 1 | Serial bit qualifier |
| in_ready | output | 1 | High when not in reset; no back-pressure |
| in_data | input | 1 | Serial data bit, LSB of each byte first |
| frame_end | input | 1 | Strobe after the last check-word bit |
| crc_out | output | 32 | Inverted register: check word to append |
| check_valid | output | 1 | One-cycle result strobe |
| check_pass | output | 1 | Residue matched |

## Verification
A wrong register bit or a wrong feedback tap shows up on `crc_out` one cycle after the affected bit is accepted. Every later bit then spreads the error across the word, so a whole-byte sweep compared against an arithmetic model exposes it within a single frame. A wrong preset or residue constant shows up on the first frame-end strobe, as `check_pass` failing on a good frame or passing on a corrupted one. A mistake in the flag timing shows up as `check_valid` high in the wrong cycle, or for more than one cycle.

// File: rtl/crc32_serial_pkg.sv
package crc32_serial_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] PRESET    = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] GOOD_RES  = 32'hDEBB20E3;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } reg_op_e;
endpackage

// File: rtl/crc32_step_reg.sv
module crc32_step_reg
  import crc32_serial_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = POLY_REFL,
  parameter logic [W-1:0] INIT = PRESET
) (
  input  logic         clk,
  input  logic         rst,
  input  reg_op_e      op,
  input  logic         bit_in,
  output logic [W-1:0] state
);
  logic [W-1:0] merged;
  logic [W-1:0] shifted;
  logic [W-1:0] stepped;
  logic         fall_bit;

  // Merge the incoming bit at the position about to leave the register.
  assign merged   = {state[W-1:1], state[0] ^ bit_in};
  assign fall_bit = merged[0];
  assign shifted  = {1'b0, merged[W-1:1]};

  // Conditional subtraction of the reflected polynomial, one tap per bit.
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (POLY[i]) begin : g_on
      assign stepped[i] = shifted[i] ^ fall_bit;
    end else begin : g_off
      assign stepped[i] = shifted[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= INIT;
    end else begin
      unique case (op)
        OP_LOAD:  state <= INIT;
        OP_SHIFT: state <= stepped;
        default:  state <= state;
      endcase
    end
  end

  p_preset_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (state == INIT));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(state));
  p_zero_bit_on_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT && state == '0 && !bit_in) |=> (state == '0));
endmodule

// File: rtl/crc32_residue_cmp.sv
module crc32_residue_cmp
  import crc32_serial_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] RESIDUE = GOOD_RES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] state,
  output logic         res_valid,
  output logic         res_pass
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
    end else begin
      res_valid <= strobe;
      res_pass  <= strobe && (state == RESIDUE);
    end
  end

  p_flag_follows_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    strobe |=> res_valid);
  p_flag_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !res_valid);
  p_pass_qualified_r7: assert property (@(posedge clk) disable iff (rst)
    res_pass |-> res_valid);
endmodule

// File: rtl/crc32_serial_unit.sv
module crc32_serial_unit
  import crc32_serial_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = POLY_REFL,
  parameter logic [W-1:0] INIT = PRESET,
  parameter logic [W-1:0] RESIDUE = GOOD_RES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_start,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_data,
  input  logic         frame_end,
  output logic [W-1:0] crc_out,
  output logic         check_valid,
  output logic         check_pass
);
  reg_op_e      op;
  logic [W-1:0] state;
  logic         take;

  assign in_ready = !rst;
  assign take     = in_valid && in_ready;

  always_comb begin
    if (frame_start)  op = OP_LOAD;
    else if (take)    op = OP_SHIFT;
    else              op = OP_HOLD;
  end

  crc32_step_reg #(.W(W), .POLY(POLY), .INIT(INIT)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .bit_in (in_data),
    .state  (state)
  );

  crc32_residue_cmp #(.W(W), .RESIDUE(RESIDUE)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (frame_end),
    .state     (state),
    .res_valid (check_valid),
    .res_pass  (check_pass)
  );

  assign crc_out = ~state;

  p_start_clears_out_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (crc_out == '0));
endmodule

// File: tb/crc32_serial_unit_test.sv
module crc32_serial_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, in_valid = 1'b0, in_data = 1'b0, frame_end = 1'b0;
  logic in_ready, check_valid, check_pass;
  logic [31:0] crc_out;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  crc32_serial_unit uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .frame_end(frame_end),
    .crc_out(crc_out), .check_valid(check_valid), .check_pass(check_pass)
  );

  logic [7:0] msg [0:15];

  function automatic logic [31:0] model_bit(logic [31:0] r, logic b);
    logic [31:0] t;
    t = r ^ {31'd0, b};
    return t[0] ? ((t >> 1) ^ 32'hEDB88320) : (t >> 1);
  endfunction

  function automatic logic [31:0] model_crc(int n);
    logic [31:0] r;
    r = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) r = model_bit(r, msg[i][k]);
    return ~r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_frame();
    frame_start = 1'b1; in_valid = 1'b1; in_data = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic push_bit(logic b, bit gap);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
    if (gap) begin
      in_data = ~b;
      @(negedge clk);
    end
  endtask

  task automatic push_bytes(int n, bit gap);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) push_bit(msg[i][k], gap);
  endtask

  task automatic push_word(logic [31:0] w);
    for (int k = 0; k < 32; k++) push_bit(w[k], 1'b0);
  endtask

  task automatic end_frame(logic exp_pass, string req);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    check(check_valid === 1'b1, "R6", {31'd0, check_valid}, 32'd1);
    check(check_pass === exp_pass, req, {31'd0, check_pass}, {31'd0, exp_pass});
    @(negedge clk);
    check(check_valid === 1'b0 && check_pass === 1'b0, "R6",
          {30'd0, check_valid, check_pass}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] w, w2;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(crc_out === 32'h0 && in_ready === 1'b0, "R8", crc_out, 32'h0);
    check(check_valid === 1'b0 && check_pass === 1'b0, "R8",
          {30'd0, check_valid, check_pass}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R8", {31'd0, in_ready}, 32'd1);
    check(check_valid === 1'b0, "R6", {31'd0, check_valid}, 32'd0);

    // R3: known vector "123456789"
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    start_frame();
    push_bytes(9, 1'b0);
    check(crc_out === 32'hCBF43926, "R3", crc_out, 32'hCBF43926);
    check(crc_out === model_crc(9), "R1", crc_out, model_crc(9));
    w = crc_out;
    push_word(w);
    end_frame(1'b1, "R4");

    // R5: idle gaps with toggling data give the same result
    start_frame();
    push_bytes(9, 1'b1);
    check(crc_out === 32'hCBF43926, "R5", crc_out, 32'hCBF43926);

    // R2: empty frame, and bit in the start cycle is discarded
    start_frame();
    check(crc_out === 32'h0, "R2", crc_out, 32'h0);
    push_word(32'h0);
    end_frame(1'b1, "R4");

    // R2: leading zero byte changes the check word
    msg[0] = 8'h00;
    for (int i = 0; i < 9; i++) msg[i+1] = 8'h31 + 8'(i);
    start_frame();
    push_bytes(10, 1'b0);
    check(crc_out === model_crc(10) && crc_out !== 32'hCBF43926, "R2",
          crc_out, model_crc(10));

    // R7: trailing zero byte after the check word fails
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    start_frame();
    push_bytes(9, 1'b0);
    push_word(32'hCBF43926);
    for (int k = 0; k < 8; k++) push_bit(1'b0, 1'b0);
    end_frame(1'b0, "R7");

    // R1/R4: sweep of every one-byte frame
    for (int v = 0; v < 256; v++) begin
      msg[0] = 8'(v);
      start_frame();
      push_bytes(1, 1'b0);
      check(crc_out === model_crc(1), "R1", crc_out, model_crc(1));
      w = crc_out;
      push_word(w);
      end_frame(1'b1, "R4");
    end

    // R7: every single-bit error in a 4-byte frame plus check word
    msg[0] = 8'hA5; msg[1] = 8'h3C; msg[2] = 8'h00; msg[3] = 8'hFF;
    w2 = model_crc(4);
    for (int e = 0; e < 64; e++) begin
      start_frame();
      for (int p = 0; p < 64; p++) begin
        logic b;
        b = (p < 32) ? msg[p/8][p%8] : w2[p-32];
        push_bit(b ^ (p == e), 1'b0);
      end
      end_frame(1'b0, "R7");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule